// File: doc/BRIEF.md
# Triggered Multi-Channel ADC Scan Sequencer

This block sequences a single shared analog-to-digital converter across a set of input channels. A rising edge on the hardware trigger input starts one scan. The scan converts every channel whose bit is set in the channel-enable mask, one after another, always from the lowest channel number to the highest. The mask is captured when the scan starts. Each result is written into that channel's own data register, and the channel's end-of-conversion flag is set. Software typically enables the interrupt bit of the highest enabled channel only, so the interrupt line fires once per completed scan.

The conversion clock is a one-cycle enable pulse, `adc_tick`, derived from the master clock by an 8-bit prescaler. The converter itself lives outside the block and is reached through a request/done pair:
- The sequencer raises `conv_start` for exactly one cycle, on a tick cycle, with the channel number on `conv_chan`.
- The converter answers with a one-cycle `conv_done` carrying `conv_result`.
- There is no back-pressure on either side. A done pulse is always accepted when a conversion is outstanding and is discarded otherwise.
- Results leave through a plain register read port: `rd_data` shows the register selected by `rd_chan` in the same cycle, and `rd_en` marks that read as consumed.

The trigger rate must not exceed the conversion rate divided by the number of enabled channels. If a trigger arrives during a scan, it is dropped and a sticky overrun flag records the loss.

Top module: `adc_scan_seq`

## Requirements
- R1: `adc_tick` pulses for one master clock cycle every 2*(P+1) cycles, where P is the 8-bit `prescal` value. This gives a period of 2 cycles at P=0 and 512 cycles at P=255.
- R2: A scan starts only on a rising edge of `trig`, sampled on the master clock, while no scan is active and the mask is nonzero. A held-high level or an edge with an empty mask starts nothing.
- R3: Within a scan, each enabled channel is converted exactly once, in ascending channel-number order. `conv_start` is a single-cycle pulse that occurs only on an `adc_tick` cycle, with `conv_chan` giving the channel.
- R4: The channel-enable mask is sampled at the trigger edge. Changes to the mask during a scan do not alter that scan.
- R5: A result accepted for channel c is stored in channel c's data register, zero-extended to 16 bits. `rd_data` equals the register selected by `rd_chan`.
- R6: Channel c's end-of-conversion flag (bit c of `eoc_flags`) is set by the edge that stores its result. It is cleared by an edge with `rd_en` high and `rd_chan`=c. When both happen at the same edge, the flag ends up set.
- R7: `irq` is high exactly when some channel has both its flag set and its `ie_mask` bit set.
- R8: A trigger rising edge during an active scan is ignored and sets `overrun`. `overrun` stays set until an edge with `ovr_clr` high and no new overrun; a new overrun wins over the clear.
- R9: `soft_rst` high at an edge returns every register to its reset value, aborting any scan. This covers the data registers, flags, overrun, prescaler count and trigger history.
- R10: `busy` rises at the edge that accepts a trigger and falls at the edge that stores the scan's last result.
- R11: A `conv_done` pulse when no conversion is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of all state |
| trig | input | 1 | Hardware trigger; rising edge starts a scan |
| chan_en | input | NCH | Channel-enable mask |
| ie_mask | input | NCH | Per-channel end-of-conversion interrupt enables |
| prescal | input | 8 | Conversion clock prescaler P |
| ovr_clr | input | 1 | Clears the overrun flag |
| adc_tick | output | 1 | Conversion clock enable pulse |
| conv_start | output | 1 | Converter start request, one cycle |
| conv_chan | output | log2(NCH) | Channel to convert |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | RES_W | Converter result, valid with conv_done |
| rd_en | input | 1 | Read strobe; clears the selected channel's flag |
| rd_chan | input | log2(NCH) | Channel selected for reading |
| rd_data | output | DATA_W | Selected channel's data register |
| eoc_flags | output | NCH | End-of-conversion flags |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Scan in progress |
| overrun | output | 1 | Sticky lost-trigger flag |

## Verification
The bench goes after the following corner cases, and each one exposes a specific fault:
- **Sparse mask.** A scan over a sparse mask shows whether channels are picked lowest first; a picker that ran high-to-low would put the wrong channel on `conv_chan` at the first start.
- **Mask change mid-scan.** Changing the mask during a scan catches a sequencer that reads the live mask instead of its snapshot; that design would convert channels the trigger never asked for.
- **Retrigger during a scan.** This checks the overrun path. A design that restarted would shorten `busy`, and one that lost the flag would leave `overrun` low.
- **Read at the write edge.** Holding a read on a channel across its own write edge exposes a read-wins priority as a missing flag and a missing `irq`.
- **Stray done, held trigger, empty mask.** A stray done pulse while idle, a trigger held high after a scan, and an empty-mask trigger must all leave every output unchanged.
- **Prescaler extremes.** Prescaler values 0, 5 and 255 expose an off-by-one in the divider through the tick spacing.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seq_state_e;

  localparam int unsigned PRESCAL_W = 8;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int PW = adc_scan_pkg::PRESCAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [PW-1:0] prescal,
  output logic          tick
);
  localparam int CNT_W = PW + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // Terminal count 2*(P+1)-1, so one tick every 2*(P+1) cycles.
  assign limit = {prescal, 1'b1};
  assign tick  = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (soft_rst || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: the shortest legal period is two cycles
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    tick |=> !tick);

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic [CW-1:0]  idx,
  output logic           any
);
  // Lowest set bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           trig,
  input  logic [NCH-1:0] chan_en,
  input  logic           adc_tick,
  input  logic           conv_done,
  input  logic           ovr_clr,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  output logic           busy,
  output logic           wr_en,
  output logic [CW-1:0]  wr_ch,
  output logic           overrun
);
  seq_state_e     state_q;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_nxt;
  logic [CW-1:0]  cur_q;
  logic           trig_q;
  logic           trig_rise;
  logic           ovr_q;
  logic [NCH-1:0] pick_in;
  logic [CW-1:0]  pick_idx;
  logic           pick_any;
  logic           done_ok;

  assign trig_rise = trig && !trig_q;
  assign done_ok   = (state_q == S_WAIT) && conv_done;
  assign pend_nxt  = pend_q & ~(NCH'(1) << cur_q);
  assign pick_in   = (state_q == S_IDLE) ? chan_en : pend_nxt;

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .req (pick_in),
    .idx (pick_idx),
    .any (pick_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
      trig_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (soft_rst) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
      trig_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      trig_q <= trig;
      if (trig_rise && state_q != S_IDLE) begin
        ovr_q <= 1'b1;
      end else if (ovr_clr) begin
        ovr_q <= 1'b0;
      end
      unique case (state_q)
        S_IDLE: begin
          if (trig_rise && pick_any) begin
            pend_q  <= chan_en;
            cur_q   <= pick_idx;
            state_q <= S_REQ;
          end
        end
        S_REQ: begin
          if (adc_tick) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (conv_done) begin
            pend_q <= pend_nxt;
            if (pick_any) begin
              cur_q   <= pick_idx;
              state_q <= S_REQ;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign conv_start = (state_q == S_REQ) && adc_tick;
  assign conv_chan  = cur_q;
  assign busy       = (state_q != S_IDLE);
  assign wr_en      = done_ok;
  assign wr_ch      = cur_q;
  assign overrun    = ovr_q;

  // R3: channels advance strictly upward within a scan
  p_asc_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (done_ok && pick_any) |=> (cur_q > $past(cur_q)));

  // R3: a start only targets a channel still pending in the snapshot
  p_start_pend_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    conv_start |-> pend_q[cur_q]);

  // R3: start is a single-cycle pulse
  p_single_start_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    conv_start |=> !conv_start);

  // R8: a retrigger during a scan is recorded
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (trig_rise && busy) |=> overrun);

  // R8: a retrigger does not abort the scan
  p_ovr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (trig_rise && busy && !done_ok) |=> busy);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int RW  = 12,
  parameter int DW  = 16,
  localparam int CW = $clog2(NCH),
  localparam int NSLOT = 1 << CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_ch,
  input  logic [RW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [CW-1:0]  rd_ch,
  input  logic [NCH-1:0] ie,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] eoc,
  output logic           irq
);
  logic [RW-1:0]  data_q [NSLOT];
  logic [NCH-1:0] eoc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) data_q[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < NSLOT; i++) data_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (i < NCH && wr_ch == CW'(i)) data_q[i] <= wr_data;
      end
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          eoc_q[g] <= 1'b0;
        end else if (soft_rst) begin
          eoc_q[g] <= 1'b0;
        end else if (wr_en && wr_ch == CW'(g)) begin
          eoc_q[g] <= 1'b1;
        end else if (rd_en && rd_ch == CW'(g)) begin
          eoc_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign rd_data = DW'(data_q[rd_ch]);
  assign eoc     = eoc_q;
  assign irq     = |(eoc_q & ie);

  // R6: a stored result always raises its flag, even under a same-edge read
  p_eoc_set_r6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    wr_en |=> eoc_q[$past(wr_ch)]);

  // R6: a read with no competing write clears the flag
  p_eoc_clr_r6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (rd_en && !(wr_en && wr_ch == rd_ch)) |=> !eoc_q[$past(rd_ch)]);

  // R5: the stored value is what the converter delivered
  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    wr_en |=> (data_q[$past(wr_ch)] == $past(wr_data)));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH    = 8,
  parameter int RES_W  = 12,
  parameter int DATA_W = 16,
  parameter int PS_W   = adc_scan_pkg::PRESCAL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   trig,
  input  logic [NCH-1:0]         chan_en,
  input  logic [NCH-1:0]         ie_mask,
  input  logic [PS_W-1:0]        prescal,
  input  logic                   ovr_clr,
  output logic                   adc_tick,
  output logic                   conv_start,
  output logic [$clog2(NCH)-1:0] conv_chan,
  input  logic                   conv_done,
  input  logic [RES_W-1:0]       conv_result,
  input  logic                   rd_en,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NCH-1:0]         eoc_flags,
  output logic                   irq,
  output logic                   busy,
  output logic                   overrun
);
  localparam int CW = $clog2(NCH);

  logic          wr_en;
  logic [CW-1:0] wr_ch;

  adc_clk_div #(.PW(PS_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .prescal  (prescal),
    .tick     (adc_tick)
  );

  adc_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .trig       (trig),
    .chan_en    (chan_en),
    .adc_tick   (adc_tick),
    .conv_done  (conv_done),
    .ovr_clr    (ovr_clr),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_ch      (wr_ch),
    .overrun    (overrun)
  );

  adc_result_bank #(.NCH(NCH), .RW(RES_W), .DW(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_data  (conv_result),
    .rd_en    (rd_en),
    .rd_ch    (rd_chan),
    .ie       (ie_mask),
    .rd_data  (rd_data),
    .eoc      (eoc_flags),
    .irq      (irq)
  );

  // R7: no interrupt without a pending flag
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eoc_flags != '0));

  // R11: a done pulse while idle leaves the flags alone
  p_stray_done_r11: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (conv_done && !busy && !rd_en) |=> $stable(eoc_flags));

endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  localparam int NCH = 8;
  localparam int CW  = 3;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n = 1'b0, soft_rst = 1'b0, trig = 1'b0, ovr_clr = 1'b0;
  logic [NCH-1:0] chan_en = '0, ie_mask = '0;
  logic [7:0]     prescal = '0;
  logic           adc_tick, conv_start, conv_done = 1'b0;
  logic [CW-1:0]  conv_chan;
  logic [11:0]    conv_result = '0;
  logic           rd_en = 1'b0;
  logic [CW-1:0]  rd_chan = '0;
  logic [15:0]    rd_data;
  logic [NCH-1:0] eoc_flags;
  logic           irq, busy, overrun;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .trig(trig),
    .chan_en(chan_en), .ie_mask(ie_mask), .prescal(prescal), .ovr_clr(ovr_clr),
    .adc_tick(adc_tick), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .rd_en(rd_en),
    .rd_chan(rd_chan), .rd_data(rd_data), .eoc_flags(eoc_flags), .irq(irq),
    .busy(busy), .overrun(overrun)
  );

  int checks = 0, errors = 0, cyc = 0;

  // reference model state
  int       m_data [NCH];
  bit [NCH-1:0] m_eoc;
  int       m_q [$];
  bit       m_active, m_ovr, m_prev;
  // converter stub state
  bit       s_pend;
  int       s_cnt, s_ch, s_seq;
  // tick spacing
  int       last_tick = -1;
  int       p_seen = 0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) m_data[i] = 0;
    m_eoc = '0; m_q.delete(); m_active = 0; m_ovr = 0; m_prev = 0;
  endtask

  task automatic step();
    bit rise, was_active, wr;
    int wch;
    @(negedge clk);
    cyc++;
    // model: apply what the design saw at the edge just passed
    if (!rst_n || soft_rst) begin
      model_reset();
    end else begin
      rise = trig && !m_prev;
      m_prev = trig;
      was_active = m_active;
      if (rise && was_active) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
      if (rise && !was_active && chan_en != 0) begin
        for (int i = 0; i < NCH; i++) if (chan_en[i]) m_q.push_back(i);
        m_active = 1;
      end
      wr = 0; wch = 0;
      if (conv_done && was_active && m_q.size() > 0) begin
        wch = m_q.pop_front();
        wr = 1;
        m_data[wch] = int'(conv_result);
        if (m_q.size() == 0) m_active = 0;
      end
      if (rd_en && !(wr && wch == int'(rd_chan))) m_eoc[rd_chan] = 1'b0;
      if (wr) m_eoc[wch] = 1'b1;
    end
    // compare every cycle
    chk(busy == m_active, "R10", "busy", busy, m_active);
    chk(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
    chk(eoc_flags == m_eoc, "R6", "eoc_flags", eoc_flags, m_eoc);
    chk(irq == |(m_eoc & ie_mask), "R7", "irq", irq, |(m_eoc & ie_mask));
    chk(int'(rd_data) == m_data[rd_chan], "R5", "rd_data", rd_data, m_data[rd_chan]);
    // R1 tick spacing
    if (!rst_n || soft_rst || int'(prescal) != p_seen) begin
      last_tick = -1;
      p_seen = int'(prescal);
    end else if (adc_tick) begin
      if (last_tick >= 0)
        chk(cyc - last_tick == 2 * (p_seen + 1), "R1", "tick gap", cyc - last_tick, 2 * (p_seen + 1));
      last_tick = cyc;
    end
    // converter stub
    conv_done = 1'b0;
    if (!rst_n || soft_rst) begin
      s_pend = 0;
    end else begin
      if (s_pend && adc_tick) begin
        s_cnt++;
        if (s_cnt == LAT) begin
          s_seq++;
          conv_result = 12'((s_ch * 300 + s_seq * 7 + 1) & 12'hFFF);
          conv_done = 1'b1;
          s_pend = 0;
        end
      end
      if (conv_start) begin
        chk(adc_tick, "R3", "start off tick", 0, 1);
        chk(m_q.size() > 0 && int'(conv_chan) == m_q[0], "R3", "conv_chan",
            conv_chan, (m_q.size() > 0) ? m_q[0] : -1);
        s_pend = 1; s_cnt = 0; s_ch = int'(conv_chan);
      end
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1; step(); trig = 1'b0; step();
  endtask

  task automatic wait_idle(int max_cyc);
    for (int i = 0; i < max_cyc; i++) begin
      step();
      if (!m_active) break;
    end
    chk(!m_active, "R10", "scan finished", m_active, 0);
    step(); step();
  endtask

  task automatic read_all();
    for (int c = 0; c < NCH; c++) begin
      rd_chan = CW'(c); rd_en = 1'b1; step();
      rd_en = 1'b0; step();
    end
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) step();
    rst_n = 1'b1; step();
    // R9 reset state
    chk(eoc_flags == 0 && !busy && !overrun && !irq, "R9", "reset state", eoc_flags, 0);

    // R3 sparse mask, ascending order, irq on last channel (R7)
    prescal = 8'd0; chan_en = 8'hA5; ie_mask = 8'h80;
    pulse_trig(); wait_idle(200);
    chk(irq == 1'b1, "R7", "irq after scan", irq, 1);
    read_all();

    // R8 retrigger during scan, then clear
    chan_en = 8'hFF;
    pulse_trig(); repeat (10) step(); pulse_trig(); wait_idle(400);
    chk(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0; step();
    read_all();

    // R4 mask snapshot
    chan_en = 8'h0F; ie_mask = 8'h08;
    pulse_trig(); repeat (3) step(); chan_en = 8'hF0; wait_idle(300);
    chk(eoc_flags == 8'h0F, "R4", "flags from snapshot", eoc_flags, 8'h0F);
    read_all();

    // R2 empty mask and held level
    chan_en = 8'h00; pulse_trig(); repeat (5) step();
    chk(!busy, "R2", "empty mask no scan", busy, 0);
    chan_en = 8'h10; trig = 1'b1; step(); wait_idle(200);
    repeat (30) step();
    chk(!busy, "R2", "held trigger no rescan", busy, 0);
    trig = 1'b0; step();
    read_all();

    // R6 read held across the write edge
    chan_en = 8'h08; ie_mask = 8'h08; rd_chan = 3'd3; rd_en = 1'b1;
    pulse_trig(); wait_idle(200);
    rd_en = 1'b0; step();

    // R11 stray done while idle
    conv_result = 12'hABC; conv_done = 1'b1; step();
    repeat (3) step();
    chk(eoc_flags == 0, "R11", "stray done ignored", eoc_flags, 0);

    // R1 prescaler values
    prescal = 8'd5; repeat (60) step();
    prescal = 8'd255; chan_en = 8'h40; ie_mask = 8'h40;
    pulse_trig(); wait_idle(4000);
    chk(irq == 1'b1, "R7", "irq slow scan", irq, 1);

    // R9 soft reset mid-scan with overrun pending
    prescal = 8'd1; chan_en = 8'hFF;
    pulse_trig(); repeat (6) step(); pulse_trig(); repeat (8) step();
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    chk(!busy && !overrun && eoc_flags == 0, "R9", "soft reset clears", busy, 0);
    repeat (20) step();
    pulse_trig(); wait_idle(500);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule